// File: doc/BRIEF.md
# Multi-lane packet byte striper

This block sits between the transmit symbol scheduler and the per-lane line encoders of a serial link that runs on one, four or twelve lanes. It takes one symbol per cycle, each with a control flag and start/end-of-packet markers, and deals them out to the lanes one at a time. A column, holding one symbol for every active lane, is presented once all active lanes of that column are filled.

The striper keeps the lanes aligned to packet boundaries. Every packet begins on lane 0. On a twelve-lane link, a packet that ends on lane 3 or lane 7 has the rest of its column filled with PAD control symbols. Between packets it produces one of two outputs. The first is a per-lane pseudo-random idle column, and each lane runs its own generator from its own seed. The second is a four-column clock-compensation skip set. The skip set is sent on every active lane in the same columns and is taken only at a packet boundary. A sticky error flag reports framing mistakes in the incoming stream.

Top module: `lane_striper`

## Requirements
- R1: While reset is held, out_valid and err are 0; the first packet after reset starts on lane 0.
- R2: lane_mode 0 selects 1 active lane, 1 selects 4, 2 selects 12, and the reserved value 3 behaves as 1; lanes at or above the active count always carry symbol 0 with K flag 0.
- R3: Packet symbols go to lanes 0, 1, 2, … in arrival order. The column, with lane l in out_sym bits [8l+7:8l] and out_k bit l, is presented with out_valid high in the cycle after the symbol that fills the last active lane.
- R4: On a 12-lane link, an end-marked symbol on lane 3 or 7 closes the column: all higher lanes carry PAD (0xF7, K=1), and the next packet starts on lane 0.
- R5: When no packet is in progress, the lane pointer is at 0, no symbol is offered and no skip is pending, an idle column is presented each cycle. Lane l carries the low 8 bits of an 11-bit register seeded with (l+1)*137, with K=0. The register advances after each idle column to {s[9:0], s[10]^s[8]}.
- R6: A held skip_req is taken at the first boundary cycle with in_valid low. The striper then sends four columns: COM (0xBC, K=1) on all active lanes, followed by three columns of SKP (0x1C, K=1). A request raised during a packet waits until that packet has ended.
- R7: An end-marked symbol that does not bring the packet length (start through end, inclusive) to a multiple of four sets err.
- R8: A start-marked symbol that arrives while the lane pointer is not at lane 0 sets err.
- R9: A symbol offered while a skip set is being sent is dropped (it appears on no lane) and sets err.
- R10: Once set, err stays 1 until reset.
- R11: While a packet is in progress and no symbol is offered, out_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_mode | input | 2 | Active lane count select |
| in_valid | input | 1 | Symbol offered this cycle |
| in_sym | input | 8 | Symbol value |
| in_k | input | 1 | Symbol is a control character |
| in_sop | input | 1 | Symbol starts a packet |
| in_eop | input | 1 | Symbol ends a packet |
| skip_req | input | 1 | Level request for a skip set |
| out_valid | output | 1 | Column present |
| out_sym | output | 96 | Column symbols, lane l at bits [8l+7:8l] |
| out_k | output | 12 | Column control flags, lane l at bit l |
| err | output | 1 | Sticky framing error |

## Verification
The hardest situation to reach is a skip request that overlaps a 12-lane packet which ends on lane 3. The request must wait through the PAD-filled column, and the COM column must follow on the very next idle cycle with no idle column between them. The bench holds skip_req high from the start of such a packet until the skip has started. A second hard case is a symbol offered during the three SKP columns. The bench offers one there and confirms that it does not appear in any later column. A bench-side model tracks the lane pointer, the idle generators and the skip phase, so that every cycle's column is predicted across sweeps of packet lengths in every mode.

// File: rtl/lane_striper_pkg.sv
package lane_striper_pkg;
   typedef enum logic [1:0] {
      LM_X1  = 2'd0,
      LM_X4  = 2'd1,
      LM_X12 = 2'd2,
      LM_RSV = 2'd3
   } lane_mode_e;

   // number of lanes carrying traffic for a mode code
   function automatic int active_lanes(input logic [1:0] mode);
      case (mode)
         2'd1:    return 4;
         2'd2:    return 12;
         default: return 1;
      endcase
   endfunction
endpackage

// File: rtl/st_idle_lfsr.sv
module st_idle_lfsr #(
   parameter int           W     = 11,
   parameter int           OUT_W = 8,
   parameter int           TAP_A = 10,
   parameter int           TAP_B = 8,
   parameter logic [W-1:0] SEED  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [OUT_W-1:0] sym
);
   if (SEED == '0) begin : g_bad_seed
      $error("idle generator seed must be nonzero");
   end
   if (OUT_W > W || TAP_A >= W || TAP_B >= W) begin : g_bad_width
      $error("idle generator geometry out of range");
   end

   logic [W-1:0] state;

   always_ff @(posedge clk) begin
      if (!rst_n)   state <= SEED;
      else if (adv) state <= {state[W-2:0], state[TAP_A] ^ state[TAP_B]};
   end

   assign sym = state[OUT_W-1:0];
endmodule

// File: rtl/st_frame_rules.sv
module st_frame_rules #(
   parameter int MULT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic drop,
   input  logic sop,
   input  logic eop,
   input  logic ptr_zero,
   output logic err
);
   localparam int CW = (MULT > 1) ? $clog2(MULT) : 1;

   if ((MULT & (MULT - 1)) != 0 || MULT < 2) begin : g_bad_mult
      $error("packet length granule must be a power of two");
   end

   logic [CW-1:0] cnt, cnt_n;
   logic          bad;

   always_comb begin
      cnt_n = sop ? CW'(1) : cnt + CW'(1);
      bad   = drop || (take && ((sop && !ptr_zero) || (eop && cnt_n != '0)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         err <= 1'b0;
      end else begin
         if (take) cnt <= cnt_n;
         if (bad)  err <= 1'b1;
      end
   end
endmodule

// File: rtl/lane_striper.sv
module lane_striper
   import lane_striper_pkg::*;
#(
   parameter int               MAX_LANES = 12,
   parameter int               SYM_W     = 8,
   parameter int               LFSR_W    = 11,
   parameter int               SEED_STEP = 137,
   parameter int               SKIP_LEN  = 4,
   parameter int               LEN_MULT  = 4,
   parameter logic [SYM_W-1:0] COM_SYM   = 8'hBC,
   parameter logic [SYM_W-1:0] SKP_SYM   = 8'h1C,
   parameter logic [SYM_W-1:0] PAD_SYM   = 8'hF7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 lane_mode,
   input  logic                       in_valid,
   input  logic [SYM_W-1:0]           in_sym,
   input  logic                       in_k,
   input  logic                       in_sop,
   input  logic                       in_eop,
   input  logic                       skip_req,
   output logic                       out_valid,
   output logic [MAX_LANES*SYM_W-1:0] out_sym,
   output logic [MAX_LANES-1:0]       out_k,
   output logic                       err
);
   localparam int PTR_W = $clog2(MAX_LANES);
   localparam int SK_W  = $clog2(SKIP_LEN);

   if (MAX_LANES != 12) begin : g_bad_lanes
      $error("striper is built for a twelve-lane maximum");
   end
   if (SYM_W < 8 || LFSR_W < SYM_W) begin : g_bad_sym
      $error("symbol or idle generator width out of range");
   end
   if (SKIP_LEN < 2 || (SKIP_LEN & (SKIP_LEN - 1)) != 0) begin : g_bad_skip
      $error("skip set length must be a power of two of at least two");
   end
   if (SEED_STEP * MAX_LANES >= (1 << LFSR_W)) begin : g_bad_seed
      $error("idle seeds would wrap");
   end

   logic [PTR_W-1:0]                  ptr;
   logic                              inpkt;
   logic [SK_W-1:0]                   sk;
   logic [MAX_LANES-1:0][SYM_W-1:0]   hold_sym, mrg_sym, col_sym, idle_sym;
   logic [MAX_LANES-1:0]              hold_k, mrg_k, col_k;
   int                                nact;
   logic skip_busy, take, drop, boundary, skip_go, idle_go, pad_end, col_full, emit;

   // one pseudo-random idle generator per lane, each from its own seed
   for (genvar g = 0; g < MAX_LANES; g++) begin : g_idle
      st_idle_lfsr #(
         .W(LFSR_W), .OUT_W(SYM_W), .TAP_A(LFSR_W - 1), .TAP_B(LFSR_W - 3),
         .SEED(LFSR_W'((g + 1) * SEED_STEP))
      ) u_lfsr (
         .clk(clk), .rst_n(rst_n), .adv(idle_go), .sym(idle_sym[g])
      );
   end

   st_frame_rules #(.MULT(LEN_MULT)) u_rules (
      .clk(clk), .rst_n(rst_n), .take(take), .drop(drop),
      .sop(in_sop), .eop(in_eop), .ptr_zero(ptr == '0), .err(err)
   );

   always_comb begin
      nact      = active_lanes(lane_mode);
      skip_busy = (sk != '0);
      take      = in_valid && !skip_busy;
      drop      = in_valid && skip_busy;
      boundary  = !inpkt && (ptr == '0);
      skip_go   = !in_valid && !skip_busy && boundary && skip_req;
      idle_go   = !in_valid && !skip_busy && boundary && !skip_req;
      pad_end   = take && in_eop && (lane_mode == LM_X12) &&
                  (ptr == PTR_W'(3) || ptr == PTR_W'(7));
      col_full  = take && ((int'(ptr) == nact - 1) || pad_end);
      emit      = col_full || skip_go || idle_go || skip_busy;

      for (int l = 0; l < MAX_LANES; l++) begin
         if (l == int'(ptr)) begin
            mrg_sym[l] = in_sym;
            mrg_k[l]   = in_k;
         end else if (pad_end && l > int'(ptr)) begin
            mrg_sym[l] = PAD_SYM;
            mrg_k[l]   = 1'b1;
         end else begin
            mrg_sym[l] = hold_sym[l];
            mrg_k[l]   = hold_k[l];
         end

         if (l >= nact) begin
            col_sym[l] = '0;
            col_k[l]   = 1'b0;
         end else if (skip_busy) begin
            col_sym[l] = SKP_SYM;
            col_k[l]   = 1'b1;
         end else if (skip_go) begin
            col_sym[l] = COM_SYM;
            col_k[l]   = 1'b1;
         end else if (idle_go) begin
            col_sym[l] = idle_sym[l];
            col_k[l]   = 1'b0;
         end else begin
            col_sym[l] = mrg_sym[l];
            col_k[l]   = mrg_k[l];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr       <= '0;
         inpkt     <= 1'b0;
         sk        <= '0;
         hold_sym  <= '0;
         hold_k    <= '0;
         out_valid <= 1'b0;
         out_sym   <= '0;
         out_k     <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_sym <= col_sym;
            out_k   <= col_k;
         end
         if (take) begin
            hold_sym <= mrg_sym;
            hold_k   <= mrg_k;
            ptr      <= col_full ? '0 : ptr + PTR_W'(1);
            if (in_eop)      inpkt <= 1'b0;
            else if (in_sop) inpkt <= 1'b1;
         end
         if (skip_go)        sk <= SK_W'(1);
         else if (skip_busy) sk <= sk + SK_W'(1);
      end
   end
endmodule

// File: rtl/lane_striper_chk.sv
module lane_striper_chk
   import lane_striper_pkg::*;
#(
   parameter int               MAX_LANES = 12,
   parameter int               SYM_W     = 8,
   parameter int               PTR_W     = 4,
   parameter int               SK_W      = 2,
   parameter logic [SYM_W-1:0] COM_SYM   = 8'hBC,
   parameter logic [SYM_W-1:0] SKP_SYM   = 8'h1C
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [1:0]                 lane_mode,
   input logic                       in_valid,
   input logic                       in_sop,
   input logic                       skip_req,
   input logic                       out_valid,
   input logic [MAX_LANES*SYM_W-1:0] out_sym,
   input logic [MAX_LANES-1:0]       out_k,
   input logic                       err,
   input logic [PTR_W-1:0]           ptr,
   input logic                       inpkt,
   input logic [SK_W-1:0]            sk
);
   // R10
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R8
   a_r8_start_off_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && sk == '0 && ptr != '0) |=> err);

   // R2
   a_r2_x4_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(lane_mode) == 2'd1) |->
      (out_sym[MAX_LANES*SYM_W-1:4*SYM_W] == '0 && out_k[MAX_LANES-1:4] == '0));

   // R3
   a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < active_lanes(lane_mode));

   // R6
   a_r6_com_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      (sk == '0 && !in_valid && !inpkt && ptr == '0 && skip_req) |=>
      (out_valid && out_k[0] && out_sym[SYM_W-1:0] == COM_SYM));

   // R6
   a_r6_skp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (sk != '0) |=> (out_valid && out_k[0] && out_sym[SYM_W-1:0] == SKP_SYM));

   // R11
   a_r11_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (inpkt && !in_valid && sk == '0) |=> !out_valid);
endmodule

bind lane_striper lane_striper_chk #(
   .MAX_LANES(MAX_LANES), .SYM_W(SYM_W), .PTR_W(PTR_W), .SK_W(SK_W),
   .COM_SYM(COM_SYM), .SKP_SYM(SKP_SYM)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .in_valid(in_valid),
   .in_sop(in_sop), .skip_req(skip_req), .out_valid(out_valid),
   .out_sym(out_sym), .out_k(out_k), .err(err), .ptr(ptr), .inpkt(inpkt), .sk(sk)
);

// File: tb/sim_lane_striper.sv
module sim_lane_striper;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  lane_mode = 2'd0;
   logic        in_valid = 1'b0, in_k = 1'b0, in_sop = 1'b0, in_eop = 1'b0, skip_req = 1'b0;
   logic [7:0]  in_sym = 8'd0;
   logic        out_valid, err;
   logic [95:0] out_sym;
   logic [11:0] out_k;

   int errors = 0, checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lane_striper u0 (
      .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .in_valid(in_valid),
      .in_sym(in_sym), .in_k(in_k), .in_sop(in_sop), .in_eop(in_eop),
      .skip_req(skip_req), .out_valid(out_valid), .out_sym(out_sym),
      .out_k(out_k), .err(err)
   );

   // bench-side expectation state
   int              m_ptr, m_sk, m_cnt;
   bit              m_inpkt, m_err;
   logic [10:0]     m_lf [12];
   logic [11:0][7:0] m_hold;
   logic [11:0]     m_holdk;

   function automatic int nlanes(input logic [1:0] m);
      return (m == 2'd1) ? 4 : (m == 2'd2) ? 12 : 1;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ptr = 0; m_sk = 0; m_cnt = 0; m_inpkt = 0; m_err = 0;
      m_hold = '0; m_holdk = '0;
      for (int l = 0; l < 12; l++) m_lf[l] = 11'((l + 1) * 137);
   endtask

   task automatic do_reset(input logic [1:0] mode);
      rst_n = 1'b0; lane_mode = mode;
      in_valid = 0; in_sop = 0; in_eop = 0; in_k = 0; in_sym = 0; skip_req = 0;
      repeat (3) @(posedge clk);
      #1;
      check(out_valid == 1'b0 && err == 1'b0, "R1", "reset outputs",
            {out_valid, err}, 2'b00);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   // one cycle: drive, predict, sample after the edge
   task automatic step(input bit v, input bit sop, input bit eop, input bit kk,
                       input logic [7:0] s, input bit sreq, input string tag);
      int n, cn;
      bit e_v, padend;
      logic [11:0][7:0] e_sym;
      logic [11:0] e_k;
      n = nlanes(lane_mode);
      e_v = 0; e_sym = '0; e_k = '0;
      if (m_sk != 0) begin
         if (v) m_err = 1;
         e_v = 1;
         for (int l = 0; l < n; l++) begin e_sym[l] = 8'h1C; e_k[l] = 1; end
         m_sk = (m_sk + 1) % 4;
      end else if (v) begin
         cn = sop ? 1 : (m_cnt + 1) % 4;
         if (sop && m_ptr != 0) m_err = 1;
         if (eop && cn != 0) m_err = 1;
         m_cnt = cn;
         m_hold[m_ptr] = s; m_holdk[m_ptr] = kk;
         padend = eop && n == 12 && (m_ptr == 3 || m_ptr == 7);
         if (padend)
            for (int l = m_ptr + 1; l < 12; l++) begin m_hold[l] = 8'hF7; m_holdk[l] = 1; end
         if (padend || m_ptr == n - 1) begin
            e_v = 1;
            for (int l = 0; l < n; l++) begin e_sym[l] = m_hold[l]; e_k[l] = m_holdk[l]; end
            m_ptr = 0;
         end else m_ptr++;
         if (eop) m_inpkt = 0; else if (sop) m_inpkt = 1;
      end else if (!m_inpkt && m_ptr == 0) begin
         e_v = 1;
         if (sreq) begin
            for (int l = 0; l < n; l++) begin e_sym[l] = 8'hBC; e_k[l] = 1; end
            m_sk = 1;
         end else begin
            for (int l = 0; l < n; l++) e_sym[l] = m_lf[l][7:0];
            for (int l = 0; l < 12; l++) m_lf[l] = {m_lf[l][9:0], m_lf[l][10] ^ m_lf[l][8]};
         end
      end
      in_valid = v; in_sop = sop; in_eop = eop; in_k = kk; in_sym = s; skip_req = sreq;
      @(posedge clk);
      #1;
      if (e_v)
         check(out_valid && out_sym == e_sym && out_k == e_k, tag, "column",
               {out_valid, out_k, out_sym}, {1'b1, e_k, e_sym});
      else
         check(!out_valid, tag, "no column", out_valid, 0);
      check(err == m_err, tag, "err", err, m_err);
      @(negedge clk);
      in_valid = 0; in_sop = 0; in_eop = 0; in_k = 0;
   endtask

   task automatic packet(input int len, input int gap_at, input bit sreq, input string tag);
      for (int i = 0; i < len; i++) begin
         if (i == gap_at) begin
            step(0, 0, 0, 0, 8'h00, sreq, "R11");
            step(0, 0, 0, 0, 8'h00, sreq, "R11");
         end
         step(1, i == 0, i == len - 1, (i == 0) || (i == len - 1),
              8'((len * 16 + i * 7) & 8'hFF), sreq, tag);
      end
   endtask

   initial begin
      for (int mi = 0; mi < 3; mi++) begin
         do_reset(2'(mi));
         repeat (3) step(0, 0, 0, 0, 8'h00, 0, "R5");
         for (int len = 4; len <= 24; len += 4) begin
            packet(len, -1, 0, (mi == 2) ? "R4" : "R3");
            repeat (2) step(0, 0, 0, 0, 8'h00, 0, "R5");
         end
         packet(8, 3, 0, "R3");
         step(0, 0, 0, 0, 8'h00, 1, "R6");
         repeat (3) step(0, 0, 0, 0, 8'h00, 0, "R6");
         step(0, 0, 0, 0, 8'h00, 0, "R5");
         check(err == 1'b0, "R7", "clean traffic leaves err low", err, 0);
      end

      // skip raised during a 12-lane packet that ends on lane 3
      do_reset(2'd2);
      step(0, 0, 0, 0, 8'h00, 0, "R5");
      packet(4, -1, 1, "R6");
      step(0, 0, 0, 0, 8'h00, 1, "R6");
      repeat (3) step(0, 0, 0, 0, 8'h00, 0, "R6");
      packet(16, -1, 0, "R4");

      // reserved mode acts as one lane
      do_reset(2'd3);
      packet(4, -1, 0, "R2");
      step(0, 0, 0, 0, 8'h00, 0, "R2");

      // bad length
      do_reset(2'd1);
      packet(6, -1, 0, "R7");
      check(err == 1'b1, "R7", "length 6 flagged", err, 1);
      repeat (4) step(0, 0, 0, 0, 8'h00, 0, "R10");
      check(err == 1'b1, "R10", "err held", err, 1);

      // start not on lane 0
      do_reset(2'd1);
      step(1, 1, 0, 1, 8'hFB, 0, "R8");
      step(1, 0, 0, 0, 8'h11, 0, "R8");
      step(1, 1, 0, 1, 8'hFB, 0, "R8");
      check(err == 1'b1, "R8", "late start flagged", err, 1);

      // symbol offered during a skip set is dropped
      do_reset(2'd1);
      step(0, 0, 0, 0, 8'h00, 1, "R9");
      step(1, 1, 0, 1, 8'hFB, 0, "R9");
      step(0, 0, 0, 0, 8'h00, 0, "R9");
      step(0, 0, 0, 0, 8'h00, 0, "R9");
      step(0, 0, 0, 0, 8'h00, 0, "R9");
      check(err == 1'b1, "R9", "drop flagged", err, 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule